// File: doc/BRIEF.md
# Mode-Switched Bidirectional GPIO Port

An eight-pin I/O port for a microcontroller. It holds an output latch, a per-pin direction register and a wired-OR control bit. Software reaches these through a small synchronous register interface. In the two general-purpose modes (single-chip and bootstrap), each pin is an input or an output as its direction bit selects. Output pins are either driven push-pull or, when wired-OR is enabled, driven open-drain.

In the two bus modes (expanded and test), the pins carry the external data bus. The CPU side supplies the write data and a write strobe that turns the pad drivers on. The latch and direction register stay readable and writable in these modes, but they no longer reach the pins. The operating mode is captured while reset is asserted and then held. The pad itself is modelled as three separate per-pin signals: output enable, output value and sampled level.

Top module: `gpio_modeport`

## Requirements
- R1: Reset (synchronous, `rst_n` low) clears the latch, the direction register and the wired-OR bit. In general-purpose modes every pin is then an input, with `pin_oe_o` equal to 0.
- R2: In bus modes (`mode_i` 2 = expanded, 3 = test), `pin_oe_o` is eight copies of `bus_wr_i` and `pin_out_o` equals `bus_wdata_i`. This holds from the first cycle after reset.
- R3: `mode_i` (0 = single-chip, 1 = bootstrap, 2 = expanded, 3 = test) is sampled on every clock edge while `rst_n` is low. Changes to `mode_i` after reset have no effect on the pins.
- R4: Register map on `addr_i`: 0 = data latch, 1 = direction (1 = output), 2 = control (bit 0 = wired-OR), 3 = reads zero. A write takes effect at the clock edge where `wr_i` is high. Reads are combinational on `rd_data_o`.
- R5: A read of address 0 returns, in every mode, the latch bit for each pin whose direction bit is 1 and the sampled `pin_in_i` level for each pin whose direction bit is 0.
- R6: In general-purpose modes with wired-OR clear, `pin_oe_o` equals the direction register and `pin_out_o` equals the latch.
- R7: In general-purpose modes with wired-OR set, `pin_out_o` is 0. An output pin whose latch bit is 0 is enabled (driven low). An output pin whose latch bit is 1 is high-impedance (`pin_oe_o` bit 0). Input pins are never enabled.
- R8: In bus modes the wired-OR bit has no effect on `pin_oe_o` or `pin_out_o`.
- R9: In bus modes, writes to the latch and direction register have no effect on the pins, though they still update the registers (visible through R4 and R5 reads).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode is captured while low |
| mode_i | input | 2 | Operating mode request |
| addr_i | input | 2 | Register select |
| wr_i | input | 1 | Register write enable |
| wdata_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| bus_wr_i | input | 1 | CPU data-bus write strobe (bus modes) |
| bus_wdata_i | input | 8 | CPU data-bus write data (bus modes) |
| pin_in_i | input | 8 | Sampled pin levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |

## Verification
A corrupted latch or direction bit shows up at the ports in the same cycle. In a general-purpose mode the bad value reaches `pin_oe_o` or `pin_out_o`, and in any mode a data read exposes it, because an output bit reads the latch rather than the pin. A wrongly captured or drifting mode is also visible at once: the enables stop following the bus strobe, or start following it when they should not. The bench therefore compares all outputs and one read every cycle, against a model driven only by the port-level writes. An error is reported in the cycle it first appears.

// File: rtl/gpio_modeport.sv
module gpio_modeport #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode_i,
  input  logic [1:0]   addr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rd_data_o,
  input  logic         bus_wr_i,
  input  logic [W-1:0] bus_wdata_i,
  input  logic [W-1:0] pin_in_i,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] pin_out_o
);

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  logic [1:0]   mode_q;
  logic [W-1:0] latch_q, dir_q;
  logic         wor_q;
  logic         gp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode_i;
      latch_q <= '0;
      dir_q   <= '0;
      wor_q   <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        A_DATA:  latch_q <= wdata_i;
        A_DIR:   dir_q   <= wdata_i;
        A_CTRL:  wor_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign gp = ~mode_q[1];

  always_comb begin
    if (!gp) begin
      pin_oe_o  = {W{bus_wr_i}};
      pin_out_o = bus_wdata_i;
    end else if (wor_q) begin
      pin_oe_o  = dir_q & ~latch_q;
      pin_out_o = '0;
    end else begin
      pin_oe_o  = dir_q;
      pin_out_o = latch_q;
    end
  end

  always_comb begin
    case (addr_i)
      A_DATA:  rd_data_o = (dir_q & latch_q) | (~dir_q & pin_in_i);
      A_DIR:   rd_data_o = dir_q;
      A_CTRL:  rd_data_o = {{(W-1){1'b0}}, wor_q};
      default: rd_data_o = '0;
    endcase
  end

  assert_gp_inputs_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (gp && $past(!rst_n)) |-> (pin_oe_o == '0));

  assert_mode_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_i) && $past(addr_i) == A_DATA) |-> (latch_q == $past(wdata_i)));

  assert_gp_enable_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gp |-> ((pin_oe_o & ~dir_q) == '0));

  assert_od_never_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gp && wor_q) |-> ((pin_oe_o & pin_out_o) == '0));

  assert_bus_enable_uniform_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gp |-> (pin_oe_o == '0 || pin_oe_o == '1));

endmodule

// File: tb/test_gpio_modeport.sv
module test_gpio_modeport;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_i, addr_i;
  logic       wr_i, bus_wr_i;
  logic [7:0] wdata_i, bus_wdata_i, pin_in_i;
  logic [7:0] rd_data_o, pin_oe_o, pin_out_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] m_mode;
  logic [7:0] m_latch, m_dir;
  logic       m_wor;

  always #5 clk = ~clk;

  gpio_modeport i_gpio_modeport (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_data_o(rd_data_o), .bus_wr_i(bus_wr_i),
    .bus_wdata_i(bus_wdata_i), .pin_in_i(pin_in_i), .pin_oe_o(pin_oe_o),
    .pin_out_o(pin_out_o)
  );

  function automatic logic [7:0] exp_oe();
    if (m_mode[1]) return {8{bus_wr_i}};
    if (m_wor) return m_dir & ~m_latch;
    return m_dir;
  endfunction

  function automatic logic [7:0] exp_out();
    if (m_mode[1]) return bus_wdata_i;
    if (m_wor) return 8'h00;
    return m_latch;
  endfunction

  function automatic logic [7:0] exp_rd();
    case (addr_i)
      2'd0: return (m_dir & m_latch) | (~m_dir & pin_in_i);
      2'd1: return m_dir;
      2'd2: return {7'b0, m_wor};
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (mode %0d)", tag, act, exp, m_mode);
    end
  endtask

  task automatic check_all();
    string t;
    if (m_mode[1]) t = "R2 R8 R9";
    else if (m_wor) t = "R7";
    else t = "R6";
    cmp({t, " oe"}, pin_oe_o, exp_oe());
    cmp({t, " out"}, pin_out_o, exp_out());
    cmp(addr_i == 2'd0 ? "R5 read" : "R4 read", rd_data_o, exp_rd());
  endtask

  task automatic do_reset(input logic [1:0] md);
    @(negedge clk);
    rst_n = 1'b0; mode_i = md; wr_i = 1'b0; addr_i = 2'd0;
    bus_wr_i = 1'b0; bus_wdata_i = 8'h00; wdata_i = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mode = md; m_latch = 8'h00; m_dir = 8'h00; m_wor = 1'b0;
    @(negedge clk);
    // R1: all registers clear, gp pins inputs; R2: bus pins follow strobe
    pin_in_i = 8'h5a; bus_wr_i = 1'b1; bus_wdata_i = 8'hc3;
    #1;
    cmp("R1 oe", pin_oe_o, md[1] ? 8'hff : 8'h00);
    cmp("R1 read data", rd_data_o, 8'h5a);
    for (int a = 1; a < 4; a++) begin
      addr_i = a[1:0]; #1;
      cmp("R1 read reg", rd_data_o, 8'h00);
    end
    addr_i = 2'd0;
  endtask

  task automatic run_random(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all();
      mode_i      = 2'($urandom); // R3: must be ignored after reset
      addr_i      = 2'($urandom);
      wr_i        = ($urandom % 3) != 0;
      wdata_i     = 8'($urandom);
      bus_wr_i    = 1'($urandom);
      bus_wdata_i = 8'($urandom);
      pin_in_i    = 8'($urandom);
      @(posedge clk);
      if (wr_i) begin
        case (addr_i)
          2'd0: m_latch = wdata_i;
          2'd1: m_dir = wdata_i;
          2'd2: m_wor = wdata_i[0];
          default: ;
        endcase
      end
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk);
    case (a)
      2'd0: m_latch = d;
      2'd1: m_dir = d;
      2'd2: m_wor = d[0];
      default: ;
    endcase
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0; pin_in_i = 8'h00;
    for (int md = 0; md < 4; md++) begin
      do_reset(md[1:0]);
      // directed: open-drain with mixed latch and direction
      wr(2'd1, 8'hf0);
      wr(2'd0, 8'hcc);
      wr(2'd2, 8'h01);
      addr_i = 2'd0; pin_in_i = 8'h33; bus_wr_i = 1'b0; #1;
      cmp(md < 2 ? "R7 directed oe" : "R8 directed oe", pin_oe_o, md < 2 ? 8'h30 : 8'h00);
      cmp("R5 directed read", rd_data_o, 8'hc3);
      mode_i = ~md[1:0]; #1;
      cmp("R3 mode change ignored", pin_oe_o, md < 2 ? 8'h30 : 8'h00);
      // directed: latch write in bus mode leaves pins alone
      bus_wr_i = 1'b1; bus_wdata_i = 8'h96;
      wr(2'd0, 8'h0f);
      #1;
      cmp(md < 2 ? "R7 directed out" : "R9 directed out", pin_out_o, md < 2 ? 8'h00 : 8'h96);
      run_random(400);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule